// File: doc/BRIEF.md
# Clock Source Controller with Stop and Break Handling

This block decides which of two clocks feeds the system clock of a clock generator built around a crystal oscillator and a PLL. The oscillator and the analog PLL sit outside it and appear only as two free-running clock inputs and a lock indicator. Software sets the PLL-enable, source-select and interrupt-enable bits through a small control register. From the same register it reads back the synchronized lock level and a sticky PLL flag. The system clock is either the crystal clock divided by two or the VCO clock divided by two. The hand-over between them is glitch-free, using enables that move only while the divided clock is low and that wait for each other through synchronizers.

A level stop request parks the block. The PLL path always shuts down, the system clock and the interrupt are held low, and the select bit is cleared by hardware, so the crystal path drives the system clock once stop ends. A configuration input decides whether the crystal oscillator output keeps running during stop. While a debug break is active, a break-clear-enable input decides whether the usual read-then-write sequence may clear the PLL flag.

A request for wait mode needs no handling here: the clock sources follow the register bits whether the processor is waiting or not.

Top module: `clkgen_ctrl`

## Requirements
- R1: With select (bit 1) at 0, `sys_clk` has twice the crystal period. With select at 1 and PLL-enable (bit 0) at 1, it has twice the VCO period.
- R2: A write loads write bits 0 (PLL-enable), 1 (select) and 2 (interrupt-enable) whatever the lock level, including select at 1 while lock is low. Read bits 0 to 2 return them, bit 6 returns the synchronized lock and bit 7 the PLL flag.
- R3: While the source changes, every high and low phase of `sys_clk` lasts at least one VCO period; no shorter pulse appears.
- R4: During stop with `osc_keep` at 0, `xclk_out` and `sys_clk` stay low.
- R5: A stop request clears the select bit in hardware. After stop ends, the bit reads 0 and `sys_clk` runs at twice the crystal period.
- R6: During stop with `osc_keep` at 1, `xclk_out` keeps toggling while `sys_clk` stays low.
- R7: A change in either direction of the synchronized lock level sets the PLL flag while PLL-enable is 1 and stop is low. With PLL-enable at 0 the flag is not set.
- R8: The flag clears on a write only when a read that saw the flag at 1 came before it. A write with no such read leaves the flag set.
- R9: While `brk_active` is 1 and `brk_clr_en` is 0, reads and writes leave the flag unchanged.
- R10: While `brk_active` and `brk_clr_en` are both 1, a read then a write clears the flag, and it stays clear after the break ends.
- R11: `irq` is high exactly when the flag and interrupt-enable are both 1 and stop is low.
- R12: If a flag-setting lock change and a clearing write fall in the same cycle, the flag ends up set.
- R13: After reset, with lock low, the register reads 0x00 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xtal_clk | input | 1 | Crystal oscillator clock |
| vco_clk | input | 1 | PLL VCO clock |
| pll_lock | input | 1 | Lock indicator from the PLL, asynchronous |
| stop_req | input | 1 | Stop mode request, level, synchronous to `clk` |
| osc_keep | input | 1 | 1 keeps the crystal output running during stop |
| brk_active | input | 1 | Debug break state |
| brk_clr_en | input | 1 | 1 lets accesses clear the flag during break |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 3 | Write data: bit 0 PLL-enable, bit 1 select, bit 2 interrupt-enable |
| reg_rdata | output | 8 | Register read value |
| xclk_out | output | 1 | Gated crystal clock |
| sys_clk | output | 1 | System clock |
| irq | output | 1 | PLL interrupt |

## Verification
The PLL flag can be set by a synchronized lock edge in the same cycle that an armed write clears it. The bench first arms the clear with a read while the flag is set. It then toggles the lock input two clock cycles ahead of the write, so that the edge detector fires on the same edge that takes the write. The flag must read 1 afterwards. A second run of the same sequence with no lock change must clear it.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned B_PLLON = 0;
  localparam int unsigned B_SEL   = 1;
  localparam int unsigned B_IE    = 2;
  localparam int unsigned B_LOCK  = 6;
  localparam int unsigned B_FLAG  = 7;

  typedef struct packed {
    logic ie;
    logic sel;
    logic pll_on;
  } ctrl_t;

  localparam int unsigned WR_W = $bits(ctrl_t);
endpackage

// File: rtl/clkgen_sync.sv
module clkgen_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st_q, st_d;

  always_comb begin
    st_d[0] = d;
    for (int i = 1; i < STAGES; i++) st_d[i] = st_q[i-1];
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) st_q <= '0;
    else         st_q <= st_d;
  end

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/clkgen_path.sv
module clkgen_path #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic src_clk,
  input  logic arst_n,
  input  logic run_async,
  input  logic want_async,
  input  logic peer_en_async,
  output logic en,
  output logic gclk
);
  logic       rst_n;
  logic [2:0] in_s;
  logic       run_s, want_s, peer_s;
  logic       div_q, div_d;
  logic       en_q, en_d, en_upd;

  clkgen_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rst (
    .clk(src_clk), .arst_n(arst_n), .d(1'b1), .q(rst_n)
  );

  clkgen_sync #(.W(3), .STAGES(SYNC_STAGES)) u_in (
    .clk(src_clk), .arst_n(arst_n),
    .d({run_async, want_async, peer_en_async}), .q(in_s)
  );

  assign run_s  = in_s[2];
  assign want_s = in_s[1];
  assign peer_s = in_s[0];

  // divider parks low when the source is stopped; the enable may only
  // move on an edge where the divided clock is (or stays) low afterwards
  always_comb begin
    div_d  = run_s & ~div_q;
    en_upd = div_q | ~run_s;
    en_d   = want_s & ~peer_s & run_s;
  end

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      div_q <= div_d;
      if (en_upd) en_q <= en_d;
    end
  end

  assign en   = en_q;
  assign gclk = div_q & en_q;

  a_r3_en_moves_low: assert property (@(posedge src_clk) disable iff (!rst_n)
    !$stable(en_q) |-> !div_q);

  a_r4_div_parks_low: assert property (@(posedge src_clk) disable iff (!rst_n)
    !run_s |=> !div_q);
endmodule

// File: rtl/clkgen_regs.sv
module clkgen_regs
  import clkgen_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             lock_async,
  input  logic             stop,
  input  logic             brk,
  input  logic             brk_clr_en,
  input  logic             wr,
  input  logic             rd,
  input  logic [WR_W-1:0]  wdata,
  output logic [REG_W-1:0] rdata,
  output logic             pll_on,
  output logic             sel,
  output logic             irq
);
  logic  rst_n;
  logic  lock_s, lock_p;
  ctrl_t ctrl_q, ctrl_d;
  logic  ctrl_en;
  logic  flag_q, flag_d;
  logic  armed_q, armed_d;
  logic  chg, set_evt, blocked, clr;

  clkgen_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(arst_n), .d(1'b1), .q(rst_n)
  );

  clkgen_sync #(.W(1), .STAGES(SYNC_STAGES)) u_lock (
    .clk(clk), .arst_n(arst_n), .d(lock_async), .q(lock_s)
  );

  always_comb begin
    ctrl_en = wr | stop;
    ctrl_d  = ctrl_q;
    if (wr)   ctrl_d = ctrl_t'(wdata);
    if (stop) ctrl_d.sel = 1'b0;

    chg     = lock_s ^ lock_p;
    set_evt = chg & ctrl_q.pll_on & ~stop;
    blocked = brk & ~brk_clr_en;

    armed_d = armed_q;
    clr     = 1'b0;
    if (!blocked) begin
      if (wr) begin
        armed_d = 1'b0;
        clr     = armed_q;
      end else if (rd && flag_q) begin
        armed_d = 1'b1;
      end
    end
    flag_d = set_evt | (flag_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      lock_p  <= 1'b0;
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      lock_p  <= lock_s;
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end

  always_comb begin
    rdata          = '0;
    rdata[B_PLLON] = ctrl_q.pll_on;
    rdata[B_SEL]   = ctrl_q.sel;
    rdata[B_IE]    = ctrl_q.ie;
    rdata[B_LOCK]  = lock_s;
    rdata[B_FLAG]  = flag_q;
  end

  assign pll_on = ctrl_q.pll_on;
  assign sel    = ctrl_q.sel;
  assign irq    = flag_q & ctrl_q.ie & ~stop;

  a_r5_stop_clears_sel: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !sel);

  a_r2_write_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !stop) |=> (sel == $past(wdata[B_SEL])) && (pll_on == $past(wdata[B_PLLON])));

  a_r9_break_holds_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (brk && !brk_clr_en && !set_evt) |=> rdata[B_FLAG] == $past(rdata[B_FLAG]));

  a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> rdata[B_FLAG]);
endmodule

// File: rtl/clkgen_ctrl.sv
module clkgen_ctrl
  import clkgen_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xtal_clk,
  input  logic             vco_clk,
  input  logic             pll_lock,
  input  logic             stop_req,
  input  logic             osc_keep,
  input  logic             brk_active,
  input  logic             brk_clr_en,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [WR_W-1:0]  reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             xclk_out,
  output logic             sys_clk,
  output logic             irq
);
  localparam int unsigned NPATH = 2;

  logic             pll_on, sel;
  logic [NPATH-1:0] src, run_a, want_a, en, gclk;
  logic             xrst_n, xrun_s, gate_q;

  clkgen_regs #(.SYNC_STAGES(SYNC_STAGES)) u_regs (
    .clk(clk), .arst_n(rst_n), .lock_async(pll_lock), .stop(stop_req),
    .brk(brk_active), .brk_clr_en(brk_clr_en), .wr(reg_wr), .rd(reg_rd),
    .wdata(reg_wdata), .rdata(reg_rdata), .pll_on(pll_on), .sel(sel), .irq(irq)
  );

  // path 0: crystal, path 1: VCO
  always_comb begin
    src       = {vco_clk, xtal_clk};
    run_a[0]  = ~(stop_req & ~osc_keep);
    run_a[1]  = pll_on & ~stop_req;
    want_a[0] = ~sel & ~stop_req;
    want_a[1] = sel & ~stop_req;
  end

  for (genvar g = 0; g < NPATH; g++) begin : g_path
    clkgen_path #(.SYNC_STAGES(SYNC_STAGES)) u_path (
      .src_clk(src[g]), .arst_n(rst_n), .run_async(run_a[g]),
      .want_async(want_a[g]), .peer_en_async(en[NPATH-1-g]),
      .en(en[g]), .gclk(gclk[g])
    );
  end

  assign sys_clk = |gclk;

  // oscillator output gate, moved only while the crystal clock is low
  clkgen_sync #(.W(1), .STAGES(SYNC_STAGES)) u_xrst (
    .clk(xtal_clk), .arst_n(rst_n), .d(1'b1), .q(xrst_n)
  );

  clkgen_sync #(.W(1), .STAGES(SYNC_STAGES)) u_xrun (
    .clk(xtal_clk), .arst_n(rst_n), .d(run_a[0]), .q(xrun_s)
  );

  always_ff @(negedge xtal_clk or negedge xrst_n) begin
    if (!xrst_n) gate_q <= 1'b0;
    else         gate_q <= xrun_s;
  end

  assign xclk_out = xtal_clk & gate_q;
endmodule

// File: tb/clkgen_ctrl_test.sv
`timescale 1ns/1ps
module clkgen_ctrl_test;
  logic       clk = 1'b0, xtal_clk = 1'b0, vco_clk = 1'b0;
  logic       rst_n, pll_lock, stop_req, osc_keep, brk_active, brk_clr_en;
  logic       reg_wr, reg_rd;
  logic [2:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       xclk_out, sys_clk, irq;

  int  checks = 0, errors = 0;
  int  xcnt = 0, scnt = 0;
  bit  mon_en = 0;
  real last_t = 0.0, min_w = 1.0e9, per;

  always #4  clk = ~clk;
  always #10 xtal_clk = ~xtal_clk;
  always #3  vco_clk = ~vco_clk;

  clkgen_ctrl uut (
    .clk(clk), .rst_n(rst_n), .xtal_clk(xtal_clk), .vco_clk(vco_clk),
    .pll_lock(pll_lock), .stop_req(stop_req), .osc_keep(osc_keep),
    .brk_active(brk_active), .brk_clr_en(brk_clr_en), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .xclk_out(xclk_out), .sys_clk(sys_clk), .irq(irq)
  );

  always @(posedge xclk_out) xcnt++;
  always @(posedge sys_clk)  scnt++;
  always @(sys_clk) begin
    if (mon_en && ($realtime - last_t) < min_w) min_w = $realtime - last_t;
    last_t = $realtime;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input real act, input real exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0.2f expected %0.2f", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] v);
    @(negedge clk) begin reg_wr = 1'b1; reg_wdata = v; end
    @(negedge clk) reg_wr = 1'b0;
  endtask

  task automatic rd_reg();
    @(negedge clk) reg_rd = 1'b1;
    @(negedge clk) reg_rd = 1'b0;
  endtask

  task automatic lock_flip();
    @(negedge clk) pll_lock = ~pll_lock;
    repeat (4) @(negedge clk);
  endtask

  task automatic get_period(output real p);
    real t0;
    @(posedge sys_clk) t0 = $realtime;
    @(posedge sys_clk) p = $realtime - t0;
  endtask

  task automatic chk_flag(input string req, input logic exp);
    @(negedge clk);
    chk(reg_rdata[7] == exp, req, "flag bit7", real'(reg_rdata[7]), real'(exp));
  endtask

  initial begin
    #200us;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; pll_lock = 0; stop_req = 0; osc_keep = 0;
    brk_active = 0; brk_clr_en = 0; reg_wr = 0; reg_rd = 0; reg_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R13: reset state
    chk(reg_rdata == 8'h00, "R13", "rdata", real'(reg_rdata), 0.0);
    chk(irq == 1'b0, "R13", "irq", real'(irq), 0.0);
    #400;
    get_period(per);
    chk(per > 39.5 && per < 40.5, "R1", "xtal period", per, 40.0);

    // R2/R1/R3: select VCO while lock is low, then back
    mon_en = 1; min_w = 1.0e9;
    wr_reg(3'b011);
    @(negedge clk);
    chk(reg_rdata[1:0] == 2'b11, "R2", "sel/pll_on", real'(reg_rdata[1:0]), 3.0);
    #600;
    get_period(per);
    chk(per > 11.5 && per < 12.5, "R1", "vco period", per, 12.0);
    wr_reg(3'b001);
    #600;
    get_period(per);
    chk(per > 39.5 && per < 40.5, "R1", "xtal period after switch", per, 40.0);
    mon_en = 0;
    chk(min_w > 5.9, "R3", "shortest sys phase", min_w, 6.0);

    // R7/R8/R11
    lock_flip();
    chk(reg_rdata[6] == 1'b1, "R7", "lock bit6", real'(reg_rdata[6]), 1.0);
    chk_flag("R7", 1'b1);
    chk(irq == 1'b0, "R11", "irq with ie=0", real'(irq), 0.0);
    wr_reg(3'b101);
    chk_flag("R8", 1'b1);
    chk(irq == 1'b1, "R11", "irq with ie=1", real'(irq), 1.0);
    rd_reg(); wr_reg(3'b101);
    chk_flag("R8", 1'b0);
    chk(irq == 1'b0, "R11", "irq after clear", real'(irq), 0.0);
    wr_reg(3'b100);
    lock_flip();
    chk_flag("R7", 1'b0);

    // R12: set and clear in the same cycle
    wr_reg(3'b101);
    lock_flip();
    rd_reg();
    @(negedge clk) pll_lock = ~pll_lock;
    @(negedge clk);
    @(negedge clk) begin reg_wr = 1'b1; reg_wdata = 3'b101; end
    @(negedge clk) reg_wr = 1'b0;
    chk_flag("R12", 1'b1);
    rd_reg(); wr_reg(3'b101);
    chk_flag("R8", 1'b0);

    // R9: break without clear permission
    lock_flip();
    @(negedge clk) begin brk_active = 1; brk_clr_en = 0; end
    rd_reg(); wr_reg(3'b101);
    chk_flag("R9", 1'b1);
    @(negedge clk) brk_active = 0;
    chk_flag("R9", 1'b1);

    // R10: break with clear permission
    @(negedge clk) begin brk_active = 1; brk_clr_en = 1; end
    rd_reg(); wr_reg(3'b101);
    chk_flag("R10", 1'b0);
    @(negedge clk) begin brk_active = 0; brk_clr_en = 0; end
    repeat (3) @(negedge clk);
    chk_flag("R10", 1'b0);

    // stop sweep over keep x select
    for (int k = 0; k < 2; k++) begin
      for (int b = 0; b < 2; b++) begin
        wr_reg({1'b1, b[0], 1'b1});
        lock_flip();
        #600;
        @(negedge clk);
        chk(irq == 1'b1, "R11", "irq before stop", real'(irq), 1.0);
        osc_keep = k[0];
        @(negedge clk) stop_req = 1'b1;
        repeat (3) @(negedge clk);
        chk(reg_rdata[1] == 1'b0, "R5", "sel in stop", real'(reg_rdata[1]), 0.0);
        chk(irq == 1'b0, "R11", "irq in stop", real'(irq), 0.0);
        #200;
        xcnt = 0; scnt = 0;
        #400;
        if (k == 0) chk(xcnt == 0, "R4", "xclk edges", real'(xcnt), 0.0);
        else        chk(xcnt >= 15, "R6", "xclk edges", real'(xcnt), 20.0);
        chk(scnt == 0, k == 0 ? "R4" : "R6", "sys edges", real'(scnt), 0.0);
        @(negedge clk) stop_req = 1'b0;
        #600;
        @(negedge clk);
        chk(reg_rdata[1] == 1'b0, "R5", "sel after stop", real'(reg_rdata[1]), 0.0);
        get_period(per);
        chk(per > 39.5 && per < 40.5, "R5", "period after stop", per, 40.0);
        rd_reg(); wr_reg(3'b101);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule